// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a parameterized set of asynchronous input lines (19, 20 or 23 by default build choice; 23 here) and turns selected transitions on them into latched interrupt requests and single-cycle event pulses. Each line passes through a two-flop synchronizer. The synchronized value is compared with its value one cycle earlier. Software picks, per line, whether a rising transition, a falling transition or both count as a trigger.

A trigger, or a software write that forces one, sets that line's pending flag. The flag stays set until software clears it. The interrupt output of a line is its pending flag gated by an interrupt mask bit. The event output is a one-cycle pulse that fires on each trigger whose event mask bit is set. Software reaches six 32-bit registers through a simple synchronous request/write-enable bus. Read data comes back registered one cycle after the request.

Top module: `extint_ctrl`

## Requirements
- R1: After reset every register reads zero, and `irq_o` and `evt_o` are all zero.
- R2: The registers sit at these byte offsets: interrupt mask 0x00, event mask 0x04, rising select 0x08, falling select 0x0C, software trigger 0x10, pending 0x14. Bits at and above N_LINES read zero. Any other offset, including one that is not word aligned, reads zero and ignores writes. `rdata_o` presents the value on the clock edge after the read request and holds it until the next read.
- R3: A 0-to-1 transition on a line whose rising-select bit is 1 sets its pending bit on the third rising clock edge after the input changes. That is two synchronizer stages plus one edge-compare stage.
- R4: A 1-to-0 transition on a line whose falling-select bit is 1 sets its pending bit with the same latency as R3.
- R5: With both select bits set, either transition triggers. With neither set, no transition affects the pending bit.
- R6: `irq_o[n]` equals pending bit n AND interrupt-mask bit n at all times.
- R7: `evt_o[n]` is high for exactly the one cycle in which a trigger sets pending bit n, and only if event-mask bit n was 1 when that trigger occurred.
- R8: Writing 1 to software-trigger bit n sets that bit and pending bit n, but only if interrupt-mask bit n or event-mask bit n is 1. Otherwise the write has no effect. Writing 0 leaves a bit unchanged.
- R9: Writing 1 to pending bit n clears it and also clears software-trigger bit n. Writing 0 leaves both unchanged.
- R10: If a trigger on line n arrives in the same cycle as a write that clears pending bit n, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | N_LINES | Asynchronous external lines |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | N_LINES | Masked pending interrupt requests |
| evt_o | output | N_LINES | One-cycle event pulses |

## Verification
The latencies differ by result:
- A line transition reaches the pending bit and `evt_o` after the third rising edge.
- `irq_o` follows the pending bit and the mask with no added delay.
- Register writes take effect on the next edge.
- Read data appears one edge after the request.

The bench keeps a cycle-level model that advances on the rising edge, so each result lands in the same cycle as it does in the design. Outputs are compared on the falling edge. The expected read value is captured when the request is driven, which is before the edge that samples it.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  // word index = addr[4:2]; pending and software-trigger decode are behavioural
  typedef enum logic [2:0] {
    REG_IMASK  = 3'd0,
    REG_EMASK  = 3'd1,
    REG_RISE   = 3'd2,
    REG_FALL   = 3'd3,
    REG_SWTRIG = 3'd4,
    REG_PEND   = 3'd5
  } reg_idx_e;

  localparam int NUM_REGS = 6;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int N_LINES = 23,
  parameter int STAGES  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] line_i,
  output logic [N_LINES-1:0] cur_o,
  output logic [N_LINES-1:0] prev_o
);
  logic [N_LINES-1:0] stg_q [STAGES];
  logic [N_LINES-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[s] <= '0;
          else         stg_q[s] <= line_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[s] <= '0;
          else         stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stg_q[STAGES-1];
  end

  assign cur_o  = stg_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/extint_edge.sv
module extint_edge #(
  parameter int N_LINES = 23
) (
  input  logic [N_LINES-1:0] cur_i,
  input  logic [N_LINES-1:0] prev_i,
  input  logic [N_LINES-1:0] rise_en_i,
  input  logic [N_LINES-1:0] fall_en_i,
  output logic [N_LINES-1:0] hw_trig_o
);
  generate
    for (genvar n = 0; n < N_LINES; n++) begin : g_line
      logic up, dn;
      assign up = cur_i[n] & ~prev_i[n];
      assign dn = ~cur_i[n] & prev_i[n];
      assign hw_trig_o[n] = (up & rise_en_i[n]) | (dn & fall_en_i[n]);
    end
  endgenerate
endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
#(
  parameter int N_LINES = 23
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [N_LINES-1:0] hw_trig_i,
  output logic [N_LINES-1:0] rise_en_o,
  output logic [N_LINES-1:0] fall_en_o,
  output logic [N_LINES-1:0] imask_o,
  output logic [N_LINES-1:0] pend_o,
  output logic [N_LINES-1:0] evt_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [N_LINES-1:0] imask_q, emask_q, rise_q, fall_q, swr_q, pend_q, evt_q;
  logic [N_LINES-1:0] wd, sw_set, clr, trig;
  logic [2:0]         word_sel;
  logic               aligned, wr_en, rd_en;
  logic [NUM_REGS-1:0] wr_hit;
  logic [DATA_W-1:0]  rd_word;

  assign word_sel = addr_i[ADDR_W-1:2];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign wr_en    = req_i & we_i & aligned;
  assign rd_en    = req_i & ~we_i;
  assign wd       = wdata_i[N_LINES-1:0];

  generate
    if (N_LINES < DATA_W) begin : g_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata_i[DATA_W-1:N_LINES];
    end
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_hit
      assign wr_hit[r] = wr_en & (word_sel == 3'(r));
    end
  endgenerate

  // software trigger only lands on lines with some mask open
  assign sw_set = wr_hit[REG_SWTRIG] ? (wd & (imask_q | emask_q)) : '0;
  assign clr    = wr_hit[REG_PEND]   ? wd : '0;
  assign trig   = hw_trig_i | sw_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imask_q <= '0;
      emask_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
    end else begin
      if (wr_hit[REG_IMASK]) imask_q <= wd;
      if (wr_hit[REG_EMASK]) emask_q <= wd;
      if (wr_hit[REG_RISE])  rise_q  <= wd;
      if (wr_hit[REG_FALL])  fall_q  <= wd;
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      swr_q  <= '0;
      evt_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | trig;
      swr_q  <= (swr_q & ~clr) | sw_set;
      evt_q  <= trig & emask_q;
    end
  end

  always_comb begin
    rd_word = '0;
    if (aligned) begin
      case (word_sel)
        REG_IMASK:  rd_word[N_LINES-1:0] = imask_q;
        REG_EMASK:  rd_word[N_LINES-1:0] = emask_q;
        REG_RISE:   rd_word[N_LINES-1:0] = rise_q;
        REG_FALL:   rd_word[N_LINES-1:0] = fall_q;
        REG_SWTRIG: rd_word[N_LINES-1:0] = swr_q;
        REG_PEND:   rd_word[N_LINES-1:0] = pend_q;
        default:    rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_word;
  end

  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
  assign imask_o   = imask_q;
  assign pend_o    = pend_q;
  assign evt_o     = evt_q;

  AST_PEND_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~$past(pend_q) & ~$past(trig)) == '0)); // R3
  AST_PEND_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(pend_q) & ~pend_q & ~$past(clr)) == '0)); // R9
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(trig) & ~pend_q) == '0)); // R10
  AST_SW_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((swr_q & ~$past(swr_q) & ~$past(imask_q | emask_q)) == '0)); // R8
  AST_EVT_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_q & ~$past(emask_q)) == '0)); // R7
  AST_EVT_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_q & ~pend_q) == '0)); // R7
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int N_LINES = 23,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] line_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [N_LINES-1:0] irq_o,
  output logic [N_LINES-1:0] evt_o
);
  logic [N_LINES-1:0] cur, prev, rise_en, fall_en, hw_trig, imask, pend;

  extint_sync #(.N_LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .cur_o  (cur),
    .prev_o (prev)
  );

  extint_edge #(.N_LINES(N_LINES)) u_edge (
    .cur_i     (cur),
    .prev_i    (prev),
    .rise_en_i (rise_en),
    .fall_en_i (fall_en),
    .hw_trig_o (hw_trig)
  );

  extint_regs #(.N_LINES(N_LINES)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .hw_trig_i (hw_trig),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en),
    .imask_o   (imask),
    .pend_o    (pend),
    .evt_o     (evt_o),
    .rdata_o   (rdata_o)
  );

  assign irq_o = pend & imask;

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~pend) == '0)); // R6
endmodule

// File: tb/sim_extint_ctrl.sv
module sim_extint_ctrl;
  localparam int N = 23;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  line = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [4:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata_o;
  logic [N-1:0]  irq_o, evt_o;

  int unsigned n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  extint_ctrl #(.N_LINES(N)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_o), .irq_o(irq_o), .evt_o(evt_o)
  );

  // reference model, advanced on the rising edge
  logic [N-1:0] m_s1, m_s2, m_prev, m_imr, m_emr, m_rise, m_fall, m_sw, m_pend, m_evt;

  function automatic logic [N-1:0] f_hw();
    return (m_s2 & ~m_prev & m_rise) | (~m_s2 & m_prev & m_fall);
  endfunction
  function automatic logic [N-1:0] f_sw();
    return (req && we && addr == 5'h10) ? (wdata[N-1:0] & (m_imr | m_emr)) : '0;
  endfunction
  function automatic logic [N-1:0] f_clr();
    return (req && we && addr == 5'h14) ? wdata[N-1:0] : '0;
  endfunction
  function automatic logic [31:0] f_read(input logic [4:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      5'h00: v[N-1:0] = m_imr;
      5'h04: v[N-1:0] = m_emr;
      5'h08: v[N-1:0] = m_rise;
      5'h0C: v[N-1:0] = m_fall;
      5'h10: v[N-1:0] = m_sw;
      5'h14: v[N-1:0] = m_pend;
      default: v = '0;
    endcase
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_imr <= '0; m_emr <= '0;
      m_rise <= '0; m_fall <= '0; m_sw <= '0; m_pend <= '0; m_evt <= '0;
    end else begin
      m_s1   <= line;
      m_s2   <= m_s1;
      m_prev <= m_s2;
      m_pend <= (m_pend & ~f_clr()) | f_hw() | f_sw();
      m_sw   <= (m_sw & ~f_clr()) | f_sw();
      m_evt  <= (f_hw() | f_sw()) & m_emr;
      if (req && we) begin
        case (addr)
          5'h00: m_imr  <= wdata[N-1:0];
          5'h04: m_emr  <= wdata[N-1:0];
          5'h08: m_rise <= wdata[N-1:0];
          5'h0C: m_fall <= wdata[N-1:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  bit          rd_pend = 1'b0;
  logic [31:0] rd_exp;
  string       rd_tag;

  // one clock: compare at the falling edge, then drive the next inputs
  task automatic cyc(input logic [N-1:0] ln, input bit rq, input bit w,
                     input logic [4:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    chk(32'(irq_o), 32'(m_pend & m_imr), "R6 irq");
    chk(32'(evt_o), 32'(m_evt), "R7 evt");
    if (rd_pend) chk(rdata_o, rd_exp, rd_tag);
    rd_pend = 1'b0;
    line = ln; req = rq; we = w; addr = a; wdata = d;
    if (rq && !w) begin
      rd_pend = 1'b1;
      rd_exp  = f_read(a);
      rd_tag  = tag;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(line, 1'b0, 1'b0, 5'h0, 32'h0, "");
  endtask
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cyc(line, 1'b1, 1'b1, a, d, "");
  endtask
  task automatic rd(input logic [4:0] a, input string tag);
    cyc(line, 1'b1, 1'b0, a, 32'h0, tag);
  endtask
  task automatic set_line(input logic [N-1:0] ln);
    cyc(ln, 1'b0, 1'b0, 5'h0, 32'h0, "");
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [N-1:0] ln;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: all registers and outputs zero after reset
    @(negedge clk);
    chk(32'(irq_o), 32'h0, "R1 irq");
    chk(32'(evt_o), 32'h0, "R1 evt");
    for (int a = 0; a < 6; a++) rd(5'(a * 4), "R1 reset read");

    // R2: map, upper bits zero, unmapped/unaligned ignored
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, "R2 imask width");
    wr(5'h08, 32'hA5A5_A5A5); rd(5'h08, "R2 rise");
    wr(5'h0C, 32'h5A5A_5A5A); rd(5'h0C, "R2 fall");
    wr(5'h1C, 32'hFFFF_FFFF); rd(5'h1C, "R2 unmapped");
    wr(5'h05, 32'hFFFF_FFFF); rd(5'h04, "R2 unaligned write");
    rd(5'h01, "R2 unaligned read");
    wr(5'h08, 32'h0); wr(5'h0C, 32'h0);

    // R3: rising select on lines 0 and 5; line 1 rises with no select (R5)
    wr(5'h00, 32'h7F_FFFF); wr(5'h04, 32'h1); wr(5'h08, 32'h21);
    set_line(23'h23);
    idle(4); rd(5'h14, "R3 rising pending");
    idle(1);

    // R9: clear only line 5, then write zero
    wr(5'h14, 32'h20); rd(5'h14, "R9 w1c");
    wr(5'h14, 32'h0);  rd(5'h14, "R9 write zero");
    wr(5'h14, 32'h1);  rd(5'h14, "R9 cleared");

    // R4: falling select on line 0
    wr(5'h08, 32'h0); wr(5'h0C, 32'h1);
    set_line(23'h22);
    idle(4); rd(5'h14, "R4 falling pending");
    wr(5'h14, 32'h7F_FFFF);

    // R5: both edges on line 2
    wr(5'h08, 32'h4); wr(5'h0C, 32'h4); wr(5'h04, 32'h4);
    set_line(23'h26); idle(4); rd(5'h14, "R5 both rise");
    wr(5'h14, 32'h4);
    set_line(23'h22); idle(4); rd(5'h14, "R5 both fall");
    wr(5'h14, 32'h7F_FFFF);
    // R5: no select, no effect
    wr(5'h08, 32'h0); wr(5'h0C, 32'h0);
    set_line(23'h7F_FFFF); idle(4); rd(5'h14, "R5 none");
    set_line(23'h0); idle(4); rd(5'h14, "R5 none fall");

    // R8: software trigger blocked with both masks closed on line 7
    wr(5'h00, 32'h0); wr(5'h04, 32'h0);
    wr(5'h10, 32'h80); rd(5'h14, "R8 gated pend"); rd(5'h10, "R8 gated sw");
    wr(5'h04, 32'h80);
    wr(5'h10, 32'h80); rd(5'h10, "R8 sw set"); rd(5'h14, "R8 sw pend");
    wr(5'h00, 32'h80);
    wr(5'h14, 32'h80); rd(5'h10, "R9 sw cleared"); rd(5'h14, "R9 pend cleared");

    // R10: trigger on line 3 collides with a clear of line 3
    wr(5'h08, 32'h8); wr(5'h00, 32'h8);
    set_line(23'h8); idle(4); rd(5'h14, "R10 first set");
    set_line(23'h0); idle(3);
    set_line(23'h8); idle(1); wr(5'h14, 32'h8);
    rd(5'h14, "R10 set wins");
    idle(2);

    // random phase
    wr(5'h14, 32'h7F_FFFF);
    for (int i = 0; i < 5000; i++) begin
      int unsigned op;
      ln = line;
      for (int b = 0; b < N; b++) if ($urandom_range(7) == 0) ln[b] = ~ln[b];
      op = $urandom_range(9);
      if (op < 3)
        cyc(ln, 1'b1, 1'b1, 5'($urandom_range(6) * 4), $urandom, "");
      else if (op < 6)
        cyc(ln, 1'b1, 1'b0, 5'($urandom_range(7) * 4), 32'h0, "R2 random read");
      else
        cyc(ln, 1'b0, 1'b0, 5'h0, 32'h0, "");
    end
    idle(2);
    summary();
  end
endmodule